// File: doc/BRIEF.md
# Time-Multiplexed Second-Order IIR Filter

This block filters a stream of signed 24-bit samples through a second-order recursive section with one input gain tap, two feedback taps and three feedforward taps. It has one 24x24 multiplier and one adder. A linear sequencer with twenty states shares them across all six taps, so it handles one sample at a time. All coefficients are constants fixed at elaboration, with 8 fractional bits.

A caller presents a sample with `in_valid` while the filter is idle. Twenty clock edges later the filtered value appears on `out_sample`, and `out_done` goes high for one cycle. The internal state values w[n] are kept in a small circular history built from plain registers. The filter reads the two most recent entries and writes the new entry once per sample.

Top module: `iir_tdm_filter`

## Requirements
- R1: A synchronous active-high reset clears `out_sample` to 0 and `out_done` to 0, and empties the history. After reset, the first output is computed as though w[n-1] = w[n-2] = 0.
- R2: A sample is taken only when `in_valid` is high while the filter is idle. A `in_valid` pulse that arrives while a sample is in progress has no effect on any output value, and it produces no extra `out_done` pulse.
- R3: The sequencer steps through its twenty states in a fixed order, one state per clock. `out_done` is first seen high after the 19th rising edge that follows the accepting edge.
- R4: `out_done` is high for exactly one cycle. `out_sample` changes only on the edge that raises `out_done`, and it holds its value at all other times.
- R5: Each product is the full signed product of a 24-bit operand and a sign-extended coefficient, with bits 31 down to 8 kept. This is a floor shift by 8, so (-1)·1.0 scaled and then times 0.25 gives -1 (0xFFFFFF).
- R6: w[n] = S(G,x[n]) + S(A1,w[n-1]) + S(A2,w[n-2]) and y[n] = S(B0,w[n]) + S(B1,w[n-1]) + S(B2,w[n-2]). S is the scaling of R5. The defaults are G=256, A1=128, A2=-64, B0=64, B1=128, B2=64.
- R7: The history holds five 24-bit entries behind a pointer. The new w[n] is written at the pointer, and the pointer then steps by one modulo 5 once per sample, in the output cycle. The taps read the entries at pointer-1 and pointer-2 (mod 5).
- R8: A sample presented in the same cycle that `out_done` is high is accepted, so outputs can follow each other every 20 cycles.
- R9: All sums wrap modulo 2^24 with no saturation, including for full-scale inputs 0x7FFFFF and 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, honoured only while idle |
| in_sample | input | 24 | Signed input sample |
| out_sample | output | 24 | Signed filtered sample, held between results |
| out_done | output | 1 | One-cycle result flag |

## Verification
A corrupted history entry or a misstepped pointer does not alter the current output. It shows up in the next one or two outputs, that is within 20 to 40 cycles, as a mismatch against the arithmetic model. A broken state order or a wrong operand route corrupts the very first output after reset. A sequencer that accepts a sample while busy shows as an extra `out_done` pulse or a shifted result.

// File: rtl/iir_tdm_pkg.sv
package iir_tdm_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_G_LD, ST_G_MUL, ST_G_ACC,
        ST_A1_LD, ST_A1_MUL, ST_A1_ACC,
        ST_A2_LD, ST_A2_MUL, ST_A2_ACC,
        ST_W_WR, ST_B0_MUL, ST_B0_ACC,
        ST_B1_LD, ST_B1_MUL, ST_B1_ACC,
        ST_B2_LD, ST_B2_MUL, ST_B2_ACC,
        ST_OUT
    } state_e;

    typedef enum logic [1:0] {SRC_IN, SRC_H1, SRC_H2, SRC_ACC} src_e;

    typedef enum logic [2:0] {K_G, K_A1, K_A2, K_B0, K_B1, K_B2} coef_e;

    typedef struct packed {
        logic  load;     // capture multiplier operands
        src_e  src;      // data operand source
        coef_e coef;     // coefficient operand
        logic  mul;      // register the scaled product
        logic  acc_en;   // update accumulator
        logic  acc_clr;  // accumulator takes product alone
        logic  hist_wr;  // store accumulator into history
        logic  last;     // publish result, step pointer
    } ctrl_t;

    function automatic ctrl_t decode(state_e s);
        ctrl_t c;
        c = '0;
        case (s)
            ST_G_LD:   begin c.load = 1'b1; c.src = SRC_IN; c.coef = K_G;  end
            ST_A1_LD:  begin c.load = 1'b1; c.src = SRC_H1; c.coef = K_A1; end
            ST_A2_LD:  begin c.load = 1'b1; c.src = SRC_H2; c.coef = K_A2; end
            ST_W_WR:   begin c.load = 1'b1; c.src = SRC_ACC; c.coef = K_B0; c.hist_wr = 1'b1; end
            ST_B1_LD:  begin c.load = 1'b1; c.src = SRC_H1; c.coef = K_B1; end
            ST_B2_LD:  begin c.load = 1'b1; c.src = SRC_H2; c.coef = K_B2; end
            ST_G_MUL, ST_A1_MUL, ST_A2_MUL,
            ST_B0_MUL, ST_B1_MUL, ST_B2_MUL: c.mul = 1'b1;
            ST_G_ACC, ST_B0_ACC: begin c.acc_en = 1'b1; c.acc_clr = 1'b1; end
            ST_A1_ACC, ST_A2_ACC,
            ST_B1_ACC, ST_B2_ACC: c.acc_en = 1'b1;
            ST_OUT:    c.last = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/iir_tdm_seq.sv
module iir_tdm_seq
    import iir_tdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output state_e state,
    output logic   accept,
    output ctrl_t  ctl
);
    state_e nxt;

    assign accept = (state == ST_IDLE) && in_valid;
    assign ctl    = decode(state);

    always_comb begin
        if (state == ST_IDLE)
            nxt = in_valid ? ST_G_LD : ST_IDLE;
        else if (state == ST_OUT)
            nxt = ST_IDLE;
        else
            nxt = state_e'(5'(state) + 5'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/iir_tdm_hist.sv
module iir_tdm_hist #(
    parameter int DW    = 24,
    parameter int DEPTH = 5,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          adv,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] idx1, idx2;

    assign idx1 = (ptr  == '0) ? LAST : ptr  - 1'b1;
    assign idx2 = (idx1 == '0) ? LAST : idx1 - 1'b1;
    assign rd1  = mem[idx1];
    assign rd2  = mem[idx2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            ptr <= '0;
        end else begin
            if (wr) mem[ptr] <= wdata;
            if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/iir_tdm_mac.sv
module iir_tdm_mac
    import iir_tdm_pkg::*;
#(
    parameter int DW   = 24,
    parameter int FRAC = 8,
    parameter int CW   = 12,
    parameter logic signed [CW-1:0] C_G  = 12'sd256,
    parameter logic signed [CW-1:0] C_A1 = 12'sd128,
    parameter logic signed [CW-1:0] C_A2 = -12'sd64,
    parameter logic signed [CW-1:0] C_B0 = 12'sd64,
    parameter logic signed [CW-1:0] C_B1 = 12'sd128,
    parameter logic signed [CW-1:0] C_B2 = 12'sd64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [DW-1:0] in_sample,
    input  ctrl_t         ctl,
    input  logic [DW-1:0] h1,
    input  logic [DW-1:0] h2,
    output logic [DW-1:0] acc
);
    localparam int PWIDE = 2 * DW;

    logic        [DW-1:0]    sample_q;
    logic signed [DW-1:0]    opa, opb;
    logic        [DW-1:0]    prod_q;
    logic signed [CW-1:0]    coef_sel;
    logic        [DW-1:0]    data_sel;
    logic signed [PWIDE-1:0] prod_full;

    always_comb begin
        case (ctl.coef)
            K_G:     coef_sel = C_G;
            K_A1:    coef_sel = C_A1;
            K_A2:    coef_sel = C_A2;
            K_B0:    coef_sel = C_B0;
            K_B1:    coef_sel = C_B1;
            K_B2:    coef_sel = C_B2;
            default: coef_sel = '0;
        endcase
        case (ctl.src)
            SRC_IN:  data_sel = sample_q;
            SRC_H1:  data_sel = h1;
            SRC_H2:  data_sel = h2;
            default: data_sel = acc;
        endcase
    end

    assign prod_full = opa * opb;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            opa      <= '0;
            opb      <= '0;
            prod_q   <= '0;
            acc      <= '0;
        end else begin
            if (accept) sample_q <= in_sample;
            if (ctl.load) begin
                opa <= data_sel;
                opb <= {{(DW-CW){coef_sel[CW-1]}}, coef_sel};
            end
            if (ctl.mul) prod_q <= prod_full[DW+FRAC-1:FRAC];
            if (ctl.acc_en) acc <= ctl.acc_clr ? prod_q : acc + prod_q;
        end
    end
endmodule

// File: rtl/iir_tdm_filter.sv
module iir_tdm_filter
    import iir_tdm_pkg::*;
#(
    parameter int DW    = 24,
    parameter int FRAC  = 8,
    parameter int CW    = 12,
    parameter int DEPTH = 5,
    parameter logic signed [CW-1:0] C_G  = 12'sd256,
    parameter logic signed [CW-1:0] C_A1 = 12'sd128,
    parameter logic signed [CW-1:0] C_A2 = -12'sd64,
    parameter logic signed [CW-1:0] C_B0 = 12'sd64,
    parameter logic signed [CW-1:0] C_B1 = 12'sd128,
    parameter logic signed [CW-1:0] C_B2 = 12'sd64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    output logic [DW-1:0] out_sample,
    output logic          out_done
);
    localparam int PTR_W = $clog2(DEPTH);

    state_e           state_w;
    logic             accept;
    ctrl_t            ctl;
    logic [DW-1:0]    h1, h2, acc;
    logic [PTR_W-1:0] hist_ptr;

    iir_tdm_seq u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .state(state_w), .accept(accept), .ctl(ctl)
    );

    iir_tdm_hist #(.DW(DW), .DEPTH(DEPTH), .PW(PTR_W)) u_hist (
        .clk(clk), .rst(rst), .wr(ctl.hist_wr), .adv(ctl.last),
        .wdata(acc), .rd1(h1), .rd2(h2), .ptr(hist_ptr)
    );

    iir_tdm_mac #(
        .DW(DW), .FRAC(FRAC), .CW(CW),
        .C_G(C_G), .C_A1(C_A1), .C_A2(C_A2),
        .C_B0(C_B0), .C_B1(C_B1), .C_B2(C_B2)
    ) u_mac (
        .clk(clk), .rst(rst), .accept(accept), .in_sample(in_sample),
        .ctl(ctl), .h1(h1), .h2(h2), .acc(acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sample <= '0;
            out_done   <= 1'b0;
        end else begin
            out_done <= ctl.last;
            if (ctl.last) out_sample <= acc;
        end
    end
endmodule

// File: rtl/iir_tdm_filter_chk.sv
module iir_tdm_filter_chk
    import iir_tdm_pkg::*;
#(
    parameter int DW    = 24,
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] out_sample,
    input logic          out_done,
    input state_e        state,
    input logic [PW-1:0] ptr
);
    p_step_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_OUT) |=> (int'(state) == int'($past(state)) + 1));

    p_out_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OUT) |=> (state == ST_IDLE));

    p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !in_valid) |=> (state == ST_IDLE));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_sample) |-> out_done);

    p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < DEPTH);

    p_ptr_moves_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> out_done);

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_done) |-> (int'(ptr) == (int'($past(ptr)) + 1) % DEPTH));
endmodule

bind iir_tdm_filter iir_tdm_filter_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_sample(out_sample),
    .out_done(out_done), .state(state_w), .ptr(hist_ptr)
);

// File: tb/iir_tdm_filter_test.sv
module iir_tdm_filter_test;
    localparam int KG = 256, KA1 = 128, KA2 = -64, KB0 = 64, KB1 = 128, KB2 = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic [23:0] out_sample;
    logic        out_done;

    int checks = 0;
    int errors = 0;
    logic [23:0] w1 = '0, w2 = '0;
    logic [23:0] last_y;

    always #2 clk = ~clk;

    iir_tdm_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_sample(out_sample), .out_done(out_done)
    );

    function automatic logic [23:0] scl(input logic [23:0] d, input int k);
        longint p;
        p = longint'($signed(d)) * longint'(k);
        return p[31:8];
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Presents x at the current negedge and waits for its result.
    task automatic run(input logic [23:0] x, input bit poke, input string tag);
        logic [23:0] w, y, junk;
        bit early, moved;
        w = scl(x, KG) + scl(w1, KA1) + scl(w2, KA2);
        y = scl(w, KB0) + scl(w1, KB1) + scl(w2, KB2);
        w2 = w1; w1 = w;
        early = 1'b0; moved = 1'b0;
        junk = 24'h5A5A5A ^ x;
        in_valid = 1'b1; in_sample = x;
        @(negedge clk);
        in_valid = 1'b0; in_sample = junk;
        check(!out_done, "R4 done low after accept", {23'd0, out_done}, 24'd0);
        for (int k = 1; k <= 18; k++) begin
            in_valid = poke && (k >= 4) && (k <= 6);
            @(negedge clk);
            if (out_done) early = 1'b1;
            if (out_sample !== last_y) moved = 1'b1;
        end
        in_valid = 1'b0;
        check(!early, "R3/R8 no early done", {23'd0, early}, 24'd0);
        check(!moved, "R4 output held while busy", {23'd0, moved}, 24'd0);
        @(negedge clk);
        check(out_done === 1'b1, "R3 done after 19 edges", {23'd0, out_done}, 24'd1);
        check(out_sample === y, tag, out_sample, y);
        last_y = out_sample;
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        w1 = '0; w2 = '0; last_y = '0;
        check(out_sample === 24'd0, "R1 reset output", out_sample, 24'd0);
        check(out_done === 1'b0, "R1 reset done", {23'd0, out_done}, 24'd0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        last_y = '0;
        do_reset();

        // R5: floor scaling of a negative value from clean history
        run(24'hFFFFFF, 1'b0, "R5 model");
        check(out_sample === 24'hFFFFFF, "R5 floor shift", out_sample, 24'hFFFFFF);

        // build history, then reset and confirm it is forgotten
        for (int i = 0; i < 4; i++) run(24'd9000 + 24'(i), 1'b0, "R6 prefill");
        do_reset();
        run(24'd1000, 1'b0, "R1 first output with empty history");

        // impulse tail runs the pointer through several wraps
        for (int i = 0; i < 14; i++) run(24'd0, 1'b0, "R7 impulse tail");

        // step
        for (int i = 0; i < 30; i++) run(24'd500, 1'b0, "R6 step");

        // busy strobes must change nothing
        for (int i = 0; i < 10; i++) run(24'(i * 777) ^ 24'h00F00F, 1'b1, "R2 strobe while busy");

        // random samples over full range
        for (int i = 0; i < 60; i++) run(24'($urandom), (i % 3) == 0, "R6 random");

        // full-scale alternation wraps
        for (int i = 0; i < 20; i++) run((i % 2) ? 24'h800000 : 24'h7FFFFF, 1'b0, "R9 wrap");

        // negative step sweep
        for (int i = 0; i < 12; i++) run(24'hFFF000 - 24'(i * 4096), 1'b0, "R6 negative sweep");

        // idle: strobes gone, nothing may happen
        begin
            bit spurious;
            spurious = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (out_done || out_sample !== last_y) spurious = 1'b1;
            end
            check(!spurious, "R2 quiet while idle", {23'd0, spurious}, 24'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule